// File: doc/BRIEF.md
# Multi-Channel Memory Protection Checker

This block holds a small bank of protection entries and checks several access channels against them at the same time. Each entry consists of a configuration byte and a word-address register. Software-side logic programs both through a single register-write port that carries an entry index, a select bit and a value. Each channel presents a word address (byte address shifted right by two) and a one-hot access type. For each channel the block returns one error bit, which is raised when the access is not permitted.

The lookup is purely combinational, so an error bit follows its channel's inputs in the same cycle. Only the entry registers are clocked. An entry can match its region in one of three ways. In top-of-range mode the region is bounded by the previous entry's address register. The other two modes are a single aligned word and a naturally aligned power-of-two region. When several entries match, the lowest-numbered one decides. A locked entry is frozen against further writes. A locked top-of-range entry also freezes the address register of the entry just below it, because that register is its lower bound.

Top module: `prot_check_top`

## Requirements
- R1: After reset every configuration byte and address register is zero, so every entry is disabled and unlocked and every access on every channel is allowed.
- R2: A write with `wr_is_addr`=0 loads the configuration byte of entry `wr_idx`. In that byte, bit 7 is lock, bits 4:3 are the matching mode, bit 2 is execute, bit 1 is write and bit 0 is read. Bits 6:5 have no effect. A write with `wr_is_addr`=1 loads the address register. Either write takes effect from the clock edge that samples `wr_en`.
- R3: In mode 1 (top-of-range), entry i matches word addresses in the range lower <= a < upper. The lower bound is the address register of entry i-1, or zero for entry 0. The upper bound is entry i's own address register and is exclusive.
- R4: In mode 2, an entry matches exactly one word: the word whose address equals its address register.
- R5: In mode 3, an address register with t trailing one bits describes a region of 2^(t+3) bytes. The region is aligned to its size, and its base is the register with those low bits treated as zero.
- R6: The access type is 1 for read, 2 for write and 4 for execute. When an entry decides an access, the error bit is 0 if that entry's matching permission bit is set and 1 otherwise, whether or not the entry is locked.
- R7: When several entries match, the one with the lowest index decides.
- R8: An access that matches no entry raises its error bit if any entry is locked, and is allowed if no entry is locked.
- R9: A locked entry ignores writes to its own configuration byte and to its own address register.
- R10: While entry i is locked in mode 1, writes to the address register of entry i-1 are ignored.
- R11: An entry in mode 0 matches nothing, even when it is locked.
- R12: Every channel has its own address, type and error bit. All channels are resolved at the same time against the shared entries.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_is_addr | input | 1 | 0 selects the configuration byte, 1 selects the address register |
| wr_idx | input | IDX_W | Entry index of the write |
| wr_data | input | ADDR_W-2 | Write value; a configuration write uses bits 7:0 |
| ch_addr | input | CHANNELS*(ADDR_W-2) | Word address per channel; channel c occupies slice c |
| ch_type | input | CHANNELS*3 | One-hot access type per channel, 3 bits each |
| ch_err | output | CHANNELS | Error bit per channel |

## Verification
An error bit depends only on its channel's inputs and the current entry registers, so it is due in the same cycle as the channel inputs. There is no register between a channel's inputs and its error bit. A register write becomes visible from the rising edge that samples `wr_en`. The bench therefore drives every write at a falling edge and lowers the strobe at the next falling edge. Only then does it set the channel inputs, and it samples the error bits 1 ns later, well away from any rising edge. Lock and freeze cases are checked through the error bits: the bench first attempts a write that must be ignored, then probes an address whose result would change if that write had landed.

// File: rtl/prot_check_pkg.sv
package prot_check_pkg;

  typedef enum logic [1:0] {
    MODE_OFF   = 2'd0,
    MODE_TOR   = 2'd1,
    MODE_WORD  = 2'd2,
    MODE_POW2  = 2'd3
  } match_mode_e;

  // Field order mirrors bits 7, 4:3, 2, 1, 0 of the configuration byte.
  typedef struct packed {
    logic        lock;
    match_mode_e mode;
    logic        x;
    logic        w;
    logic        r;
  } entry_cfg_t;

  localparam int TYPE_W = 3;

endpackage

// File: rtl/prot_entry_bank.sv
module prot_entry_bank
  import prot_check_pkg::*;
#(
  parameter int ENTRIES = 8,
  parameter int WORD_W  = 30,
  parameter int IDX_W   = 3
) (
  input  logic                           clk,
  input  logic                           rst,
  input  logic                           wr_en,
  input  logic                           wr_is_addr,
  input  logic [IDX_W-1:0]               wr_idx,
  input  logic [WORD_W-1:0]              wr_data,
  output entry_cfg_t [ENTRIES-1:0]       cfg_o,
  output logic [ENTRIES-1:0][WORD_W-1:0] addr_o
);

  entry_cfg_t [ENTRIES-1:0]       cfg_q;
  logic [ENTRIES-1:0][WORD_W-1:0] addr_q;
  logic [ENTRIES-1:0]             addr_frozen;
  entry_cfg_t                     wr_cfg;

  // Bits 6:5 of the byte are dropped here.
  assign wr_cfg = entry_cfg_t'({wr_data[7], wr_data[4:0]});

  for (genvar i = 0; i < ENTRIES; i++) begin : g_frz
    if (i == ENTRIES - 1) begin : g_last
      assign addr_frozen[i] = cfg_q[i].lock;
    end else begin : g_mid
      assign addr_frozen[i] = cfg_q[i].lock |
                              (cfg_q[i+1].lock && (cfg_q[i+1].mode == MODE_TOR));
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cfg_q  <= '0;
      addr_q <= '0;
    end else if (wr_en) begin
      for (int i = 0; i < ENTRIES; i++) begin
        if (wr_idx == IDX_W'(i)) begin
          if (!wr_is_addr && !cfg_q[i].lock) cfg_q[i] <= wr_cfg;
          if (wr_is_addr && !addr_frozen[i]) addr_q[i] <= wr_data;
        end
      end
    end
  end

  assign cfg_o  = cfg_q;
  assign addr_o = addr_q;

  // R1: registers are clear in the cycle after reset
  p_reset_clear_r1: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (cfg_q == '0 && addr_q == '0));

  for (genvar i = 0; i < ENTRIES; i++) begin : g_chk
    // R9: locked entry keeps its configuration
    p_locked_cfg_hold_r9: assert property (@(posedge clk) disable iff (rst)
      cfg_q[i].lock |=> $stable(cfg_q[i]));
    // R9: locked entry keeps its address
    p_locked_addr_hold_r9: assert property (@(posedge clk) disable iff (rst)
      cfg_q[i].lock |=> $stable(addr_q[i]));
    if (i < ENTRIES - 1) begin : g_nb
      // R10: locked range entry above freezes this address
      p_tor_prev_hold_r10: assert property (@(posedge clk) disable iff (rst)
        (cfg_q[i+1].lock && cfg_q[i+1].mode == MODE_TOR) |=> $stable(addr_q[i]));
    end
  end

endmodule

// File: rtl/prot_region_match.sv
module prot_region_match
  import prot_check_pkg::*;
#(
  parameter int WORD_W = 30
) (
  input  match_mode_e       mode,
  input  logic [WORD_W-1:0] own_q,
  input  logic [WORD_W-1:0] below_q,
  input  logic [WORD_W-1:0] acc_w,
  output logic              hit
);

  logic [WORD_W-1:0] pow2_care;

  // Trailing ones plus the first zero above them are the don't-care bits.
  assign pow2_care = ~(own_q ^ (own_q + WORD_W'(1)));

  always_comb begin
    unique case (mode)
      MODE_TOR:  hit = (acc_w >= below_q) && (acc_w < own_q);
      MODE_WORD: hit = (acc_w == own_q);
      MODE_POW2: hit = ((acc_w ^ own_q) & pow2_care) == '0;
      default:   hit = 1'b0;
    endcase
  end

endmodule

// File: rtl/prot_channel_check.sv
module prot_channel_check
  import prot_check_pkg::*;
#(
  parameter int ENTRIES = 8,
  parameter int WORD_W  = 30
) (
  input  logic                           clk,
  input  logic                           rst,
  input  entry_cfg_t [ENTRIES-1:0]       cfg_i,
  input  logic [ENTRIES-1:0][WORD_W-1:0] addr_i,
  input  logic [WORD_W-1:0]              acc_w,
  input  logic [TYPE_W-1:0]              acc_type,
  output logic                           err_o
);

  logic [ENTRIES-1:0]             hit;
  logic [ENTRIES-1:0]             locked;
  logic [ENTRIES-1:0][TYPE_W-1:0] perm;
  logic [TYPE_W-1:0]              win_perm;
  logic                           any_hit;

  for (genvar k = 0; k < ENTRIES; k++) begin : g_ent
    logic [WORD_W-1:0] below;
    if (k == 0) begin : g_first
      assign below = '0;
    end else begin : g_rest
      assign below = addr_i[k-1];
    end

    prot_region_match #(.WORD_W(WORD_W)) match_i (
      .mode    (cfg_i[k].mode),
      .own_q   (addr_i[k]),
      .below_q (below),
      .acc_w   (acc_w),
      .hit     (hit[k])
    );

    assign locked[k] = cfg_i[k].lock;
    assign perm[k]   = {cfg_i[k].x, cfg_i[k].w, cfg_i[k].r};

    // R11: disabled entry never matches
    p_off_no_hit_r11: assert property (@(posedge clk) disable iff (rst)
      (cfg_i[k].mode == MODE_OFF) |-> !hit[k]);
  end

  // Lowest index wins: scan from the top so the last assignment is the lowest.
  always_comb begin
    any_hit  = 1'b0;
    win_perm = '0;
    for (int k = ENTRIES - 1; k >= 0; k--) begin
      if (hit[k]) begin
        any_hit  = 1'b1;
        win_perm = perm[k];
      end
    end
  end

  assign err_o = any_hit ? ~|(acc_type & win_perm) : |locked;

  // R7: entry 0 decides a read whenever it matches
  p_first_decides_r7: assert property (@(posedge clk) disable iff (rst)
    (hit[0] && acc_type == 3'b001) |-> (err_o == !cfg_i[0].r));
  // R8: unmatched access with a lock present is refused
  p_nomatch_locked_r8: assert property (@(posedge clk) disable iff (rst)
    (hit == '0 && locked != '0) |-> err_o);
  // R8: unmatched access with no lock is allowed
  p_nomatch_open_r8: assert property (@(posedge clk) disable iff (rst)
    (hit == '0 && locked == '0) |-> !err_o);

endmodule

// File: rtl/prot_check_top.sv
module prot_check_top
  import prot_check_pkg::*;
#(
  parameter int ENTRIES  = 8,
  parameter int CHANNELS = 3,
  parameter int ADDR_W   = 32,
  localparam int WORD_W  = ADDR_W - 2,
  localparam int IDX_W   = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic                         wr_en,
  input  logic                         wr_is_addr,
  input  logic [IDX_W-1:0]             wr_idx,
  input  logic [WORD_W-1:0]            wr_data,
  input  logic [CHANNELS*WORD_W-1:0]   ch_addr,
  input  logic [CHANNELS*TYPE_W-1:0]   ch_type,
  output logic [CHANNELS-1:0]          ch_err
);

  entry_cfg_t [ENTRIES-1:0]       cfg;
  logic [ENTRIES-1:0][WORD_W-1:0] addr;

  prot_entry_bank #(
    .ENTRIES (ENTRIES),
    .WORD_W  (WORD_W),
    .IDX_W   (IDX_W)
  ) bank_i (
    .clk        (clk),
    .rst        (rst),
    .wr_en      (wr_en),
    .wr_is_addr (wr_is_addr),
    .wr_idx     (wr_idx),
    .wr_data    (wr_data),
    .cfg_o      (cfg),
    .addr_o     (addr)
  );

  for (genvar c = 0; c < CHANNELS; c++) begin : g_ch
    prot_channel_check #(
      .ENTRIES (ENTRIES),
      .WORD_W  (WORD_W)
    ) chan_i (
      .clk      (clk),
      .rst      (rst),
      .cfg_i    (cfg),
      .addr_i   (addr),
      .acc_w    (ch_addr[c*WORD_W +: WORD_W]),
      .acc_type (ch_type[c*TYPE_W +: TYPE_W]),
      .err_o    (ch_err[c])
    );
  end

  // R1: nothing is refused in the cycle after reset
  p_open_after_reset_r1: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (ch_err == '0 || ch_type == '0));

endmodule

// File: tb/prot_check_top_tb_top.sv
module prot_check_top_tb_top;

  localparam int ENTRIES  = 8;
  localparam int CHANNELS = 3;
  localparam int ADDR_W   = 32;
  localparam int WORD_W   = ADDR_W - 2;
  localparam int IDX_W    = 3;

  logic                       clk = 1'b0;
  logic                       rst = 1'b1;
  logic                       wr_en = 1'b0;
  logic                       wr_is_addr = 1'b0;
  logic [IDX_W-1:0]           wr_idx = '0;
  logic [WORD_W-1:0]          wr_data = '0;
  logic [WORD_W-1:0]          a_ch [CHANNELS];
  logic [2:0]                 t_ch [CHANNELS];
  logic [CHANNELS*WORD_W-1:0] ch_addr;
  logic [CHANNELS*3-1:0]      ch_type;
  logic [CHANNELS-1:0]        ch_err;

  int n_chk  = 0;
  int n_fail = 0;

  always #2 clk = ~clk;

  assign ch_addr = {a_ch[2], a_ch[1], a_ch[0]};
  assign ch_type = {t_ch[2], t_ch[1], t_ch[0]};

  prot_check_top #(
    .ENTRIES  (ENTRIES),
    .CHANNELS (CHANNELS),
    .ADDR_W   (ADDR_W)
  ) dut_i (
    .clk        (clk),
    .rst        (rst),
    .wr_en      (wr_en),
    .wr_is_addr (wr_is_addr),
    .wr_idx     (wr_idx),
    .wr_data    (wr_data),
    .ch_addr    (ch_addr),
    .ch_type    (ch_type),
    .ch_err     (ch_err)
  );

  localparam logic [2:0] RD = 3'b001;
  localparam logic [2:0] WR = 3'b010;
  localparam logic [2:0] EX = 3'b100;

  task automatic check(input logic got, input logic exp, input string tag);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %0b expected %0b", tag, got, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1;
    wr_en = 1'b0;
    for (int c = 0; c < CHANNELS; c++) begin
      a_ch[c] = '0;
      t_ch[c] = RD;
    end
    repeat (2) @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic wr_reg(input bit is_addr, input int idx, input logic [WORD_W-1:0] val);
    @(negedge clk);
    wr_en = 1'b1;
    wr_is_addr = is_addr;
    wr_idx = IDX_W'(idx);
    wr_data = val;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic probe(input int ch, input logic [31:0] byte_addr, input logic [2:0] typ,
                       input logic exp, input string tag);
    a_ch[ch] = byte_addr[31:2];
    t_ch[ch] = typ;
    #1;
    check(ch_err[ch], exp, tag);
  endtask

  task automatic t_reset();
    do_reset();
    probe(0, 32'h0000_1234, RD, 1'b0, "R1 read after reset");
    probe(1, 32'hFFFF_FFFC, WR, 1'b0, "R1 write after reset");
    probe(2, 32'h0000_0000, EX, 1'b0, "R1 exec after reset");
  endtask

  task automatic t_tor();
    do_reset();
    wr_reg(1, 0, 30'h400);
    wr_reg(1, 1, 30'h800);
    wr_reg(0, 0, 30'h69);   // bits 6:5 set, mode 1, read
    wr_reg(0, 1, 30'h0A);   // mode 1, write
    probe(0, 32'h0000_0000, RD, 1'b0, "R3 entry0 lower bound zero");
    probe(0, 32'h0000_0FFC, RD, 1'b0, "R3 last word below upper");
    probe(0, 32'h0000_0000, EX, 1'b1, "R6 exec without permission");
    probe(0, 32'h0000_1000, RD, 1'b1, "R3 upper exclusive, next entry decides");
    probe(0, 32'h0000_1000, WR, 1'b0, "R3 lower bound from previous entry");
    probe(0, 32'h0000_1FFC, WR, 1'b0, "R3 entry1 top word");
    probe(0, 32'h0000_2000, WR, 1'b0, "R8 no match, no lock");
    probe(0, 32'h0000_0100, WR, 1'b1, "R2 bits 6:5 give no write");
  endtask

  task automatic t_word();
    do_reset();
    wr_reg(1, 2, 30'hC00);
    wr_reg(0, 2, 30'h94);   // lock, mode 2, exec
    probe(1, 32'h0000_3000, EX, 1'b0, "R4 single word match");
    probe(1, 32'h0000_3000, RD, 1'b1, "R6 read refused by exec-only entry");
    probe(1, 32'h0000_3004, EX, 1'b1, "R4 next word misses, R8 lock present");
    probe(1, 32'h0000_2FFC, EX, 1'b1, "R4 previous word misses");
  endtask

  task automatic t_pow2();
    do_reset();
    wr_reg(1, 3, 30'h101F);  // 256-byte region at 0x4000
    wr_reg(0, 3, 30'h1B);    // mode 3, read+write
    wr_reg(0, 7, 30'h80);    // locked but disabled
    probe(2, 32'h0000_4000, WR, 1'b0, "R5 region base");
    probe(2, 32'h0000_40FC, RD, 1'b0, "R5 region top word");
    probe(2, 32'h0000_4100, RD, 1'b1, "R5 past region, R11 locked off entry");
    probe(2, 32'h0000_3FFC, RD, 1'b1, "R5 below region");
    probe(2, 32'h0000_4080, EX, 1'b1, "R6 exec refused");
  endtask

  task automatic t_priority();
    do_reset();
    wr_reg(1, 0, 30'h1400);
    wr_reg(1, 1, 30'h141F);
    wr_reg(0, 0, 30'h11);    // mode 2, read only
    wr_reg(0, 1, 30'h1B);    // mode 3, read+write
    probe(0, 32'h0000_5000, WR, 1'b1, "R7 lower entry refuses write");
    probe(0, 32'h0000_5004, WR, 1'b0, "R7 only higher entry matches");
    wr_reg(0, 0, 30'h01);    // mode 0
    probe(0, 32'h0000_5000, WR, 1'b0, "R11 disabled entry skipped");
  endtask

  task automatic t_lock();
    do_reset();
    wr_reg(1, 0, 30'h400);
    wr_reg(1, 1, 30'h800);
    wr_reg(0, 1, 30'h89);    // lock, mode 1, read
    wr_reg(1, 1, 30'hC00);   // must be ignored
    probe(0, 32'h0000_2400, RD, 1'b1, "R9 own address write ignored");
    probe(0, 32'h0000_1FFC, RD, 1'b0, "R9 old upper bound kept");
    wr_reg(1, 0, 30'h000);   // must be ignored
    probe(0, 32'h0000_0800, RD, 1'b1, "R10 lower bound register frozen");
    wr_reg(0, 1, 30'h0F);    // must be ignored
    probe(0, 32'h0000_1000, WR, 1'b1, "R9 configuration write ignored");
    wr_reg(1, 2, 30'hC00);
    wr_reg(0, 2, 30'h0A);    // unlocked entry still writable
    probe(0, 32'h0000_2400, WR, 1'b0, "R9 unlocked entry above accepts writes");
  endtask

  task automatic t_channels();
    do_reset();
    wr_reg(1, 0, 30'h400);
    wr_reg(0, 0, 30'h8D);    // lock, mode 1, exec+read
    @(negedge clk);
    a_ch[0] = 30'h40;   t_ch[0] = RD;
    a_ch[1] = 30'h40;   t_ch[1] = WR;
    a_ch[2] = 30'h800;  t_ch[2] = EX;
    #1;
    check(ch_err[0], 1'b0, "R12 channel 0 read allowed");
    check(ch_err[1], 1'b1, "R12 channel 1 write refused");
    check(ch_err[2], 1'b1, "R12 channel 2 unmatched with lock");
    a_ch[2] = 30'h80;
    #1;
    check(ch_err[2], 1'b0, "R12 channel 2 exec allowed");
    check(ch_err[1], 1'b1, "R12 channel 1 unaffected");
  endtask

  initial begin
    for (int c = 0; c < CHANNELS; c++) begin
      a_ch[c] = '0;
      t_ch[c] = RD;
    end
    t_reset();
    t_tor();
    t_word();
    t_pow2();
    t_priority();
    t_lock();
    t_channels();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    #400000;
    n_chk++;
    n_fail++;
    $display("FAIL watchdog (all requirements): got timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule